// File: doc/BRIEF.md
# Serial-Loaded RGB PWM Pixel Driver

This block sits next to a group of sixteen RGB pixels and produces their colour locally. An upstream controller sends only colour codes: one 8-bit code for each of the red, green and blue channels of every pixel, 48 codes in all, shifted in on a serial data line qualified by a serial clock. The bits that fall off the far end of the 384-bit chain leave on a serial output, so several drivers can be wired in a daisy chain and loaded from a single stream.

A strobe copies the chain into a staging register. At the next PWM period boundary the staged codes become the displayed codes. Each code is compared with a free-running counter to form one PWM output. A frame is made of 31 PWM periods, called sub-frames. A 5-bit brightness value selects how many of those sub-frames may light the outputs. A gate input blanks all 48 outputs in the same cycle it falls, which lets an external row sequencer switch a row off quickly.

The serial clock is sampled by the system clock, and a shift occurs when that sampled clock is seen to rise. All logic runs on one clock and uses a synchronous, active-high reset.

Top module: `rgbpwm_pixel_driver`

## Requirements
- R1: Each rising edge of `sclk_i`, as sampled by `clk_i`, shifts `sdi_i` into the chain. The first bit sent is the MSB of code 0. Code j occupies bits [383-8j -: 8] once 384 bits have been shifted. `sdo_o` carries the bit that was shifted in 384 edges earlier, and is 0 after reset.
- R2: A cycle with `strobe_i` high copies the chain into staging. The displayed codes change only at the end of a PWM period, when the counter leaves 254. Neither shifting nor strobing alters the outputs before that point.
- R3: The PWM counter steps 0, 1, ..., 254 and then wraps, so one period lasts 255 cycles. A channel is high while the counter is below its code. Code 0 never lights the channel, and code 255 lights it for the whole period.
- R4: A frame lasts 31 periods, and sub-frame k (0..30) may light the outputs only when k < brightness. A brightness of 0 keeps every output dark. Over one whole frame, a channel is high for code × brightness cycles.
- R5: A change on `bright_i` takes effect only at the next period boundary.
- R6: With `gate_i` low, all of `pwm_o` is 0 in the same cycle. The counters keep running, and the outputs resume as soon as the gate returns high.
- R7: A reset clears the chain, the staging and displayed codes, the brightness in use and the counters. As a result `pwm_o` and `sdo_o` are 0 after it.
- R8: Output `pwm_o[3p+c]` belongs to pixel p, with c = 0 for red, 1 for green and 2 for blue. This means code j drives `pwm_o[j]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial shift clock, sampled by clk_i |
| sdi_i | input | 1 | Serial data in |
| strobe_i | input | 1 | Copy the chain into staging |
| gate_i | input | 1 | Output enable; low blanks all outputs at once |
| bright_i | input | 5 | Number of lit sub-frames per frame (0..31) |
| sdo_o | output | 1 | Serial data out for cascading |
| pwm_o | output | 48 | PWM outputs, index 3×pixel + channel |

## Verification
The serial-clock checks assume that `sclk_i` holds each level for at least one `clk_i` cycle. They also assume that `sdi_i` is steady at the cycle where the rising edge is sampled. The bench meets this by changing data one cycle before raising the serial clock and by holding each level for a full cycle. The latch and brightness properties assume that the counter wraps only through 254 and that strobes are single-cycle. The bench follows the counter phase by counting cycles from reset, and it places its strobes and brightness changes at chosen phases inside a period.

// File: rtl/rgbpwm_pkg.sv
package rgbpwm_pkg;

    localparam int unsigned PIXELS    = 16;
    localparam int unsigned CHANNELS  = 3;
    localparam int unsigned CODE_W    = 8;
    localparam int unsigned BRIGHT_W  = 5;

    localparam int unsigned N_CODES   = PIXELS * CHANNELS;
    localparam int unsigned CHAIN_W   = N_CODES * CODE_W;

    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2
    } chan_e;

    // Position of a code in the flat output vector.
    function automatic int unsigned code_index(int unsigned pix, chan_e ch);
        return pix * CHANNELS + int'(ch);
    endfunction

endpackage

// File: rtl/rgbpwm_shift_chain.sv
module rgbpwm_shift_chain #(
    parameter int unsigned CHAIN_W = rgbpwm_pkg::CHAIN_W
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               sclk_i,
    input  logic               sdi_i,
    output logic [CHAIN_W-1:0] chain_o,
    output logic               sdo_o
);

    logic               sclk_q;
    logic               shift_en;
    logic [CHAIN_W-1:0] chain_q;

    assign shift_en = sclk_i & ~sclk_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sclk_q  <= 1'b0;
            chain_q <= '0;
        end else begin
            sclk_q <= sclk_i;
            if (shift_en) begin
                chain_q <= {chain_q[CHAIN_W-2:0], sdi_i};
            end
        end
    end

    assign chain_o = chain_q;
    assign sdo_o   = chain_q[CHAIN_W-1];

    AST_SHIFT_ENTRY: assert property (@(posedge clk_i) disable iff (rst_i)
        shift_en |=> chain_q[0] == $past(sdi_i)); // R1
    AST_CHAIN_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !shift_en |=> $stable(chain_q)); // R1

endmodule

// File: rtl/rgbpwm_timebase.sv
module rgbpwm_timebase #(
    parameter int unsigned CODE_W   = rgbpwm_pkg::CODE_W,
    parameter int unsigned BRIGHT_W = rgbpwm_pkg::BRIGHT_W
) (
    input  logic                clk_i,
    input  logic                rst_i,
    output logic [CODE_W-1:0]   cnt_o,
    output logic [BRIGHT_W-1:0] sub_o,
    output logic                wrap_o
);

    localparam logic [CODE_W-1:0]   CNT_LAST = CODE_W'((1 << CODE_W) - 2);
    localparam logic [BRIGHT_W-1:0] SUB_LAST = BRIGHT_W'((1 << BRIGHT_W) - 2);

    logic [CODE_W-1:0]   cnt_q;
    logic [BRIGHT_W-1:0] sub_q;
    logic                wrap;

    assign wrap = (cnt_q == CNT_LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            sub_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
            sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign sub_o  = sub_q;
    assign wrap_o = wrap;

    AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q == CNT_LAST |=> cnt_q == '0); // R3
    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q != CNT_LAST |=> cnt_q == $past(cnt_q) + 1'b1); // R3
    AST_SUB_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        sub_q <= SUB_LAST); // R4

endmodule

// File: rtl/rgbpwm_frame_latch.sv
module rgbpwm_frame_latch #(
    parameter int unsigned CHAIN_W  = rgbpwm_pkg::CHAIN_W,
    parameter int unsigned BRIGHT_W = rgbpwm_pkg::BRIGHT_W
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                strobe_i,
    input  logic                wrap_i,
    input  logic [CHAIN_W-1:0]  chain_i,
    input  logic [BRIGHT_W-1:0] bright_i,
    output logic [CHAIN_W-1:0]  active_o,
    output logic [BRIGHT_W-1:0] bright_o
);

    logic [CHAIN_W-1:0]  staged_q;
    logic [CHAIN_W-1:0]  active_q;
    logic [BRIGHT_W-1:0] bright_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            staged_q <= '0;
            active_q <= '0;
            bright_q <= '0;
        end else begin
            if (strobe_i) begin
                staged_q <= chain_i;
            end
            if (wrap_i) begin
                active_q <= staged_q;
                bright_q <= bright_i;
            end
        end
    end

    assign active_o = active_q;
    assign bright_o = bright_q;

    AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !wrap_i |=> $stable(active_q)); // R2
    AST_BRIGHT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !wrap_i |=> $stable(bright_q)); // R5

endmodule

// File: rtl/rgbpwm_pixel_driver.sv
module rgbpwm_pixel_driver
    import rgbpwm_pkg::*;
#(
    parameter int unsigned NPIX   = PIXELS,
    parameter int unsigned CW     = CODE_W,
    parameter int unsigned BW     = BRIGHT_W
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       sclk_i,
    input  logic                       sdi_i,
    input  logic                       strobe_i,
    input  logic                       gate_i,
    input  logic [BW-1:0]              bright_i,
    output logic                       sdo_o,
    output logic [NPIX*CHANNELS-1:0]   pwm_o
);

    localparam int unsigned NC  = NPIX * CHANNELS;
    localparam int unsigned CHW = NC * CW;

    logic [CHW-1:0] chain;
    logic [CHW-1:0] active;
    logic [BW-1:0]  bright_use;
    logic [CW-1:0]  cnt;
    logic [BW-1:0]  sub;
    logic           wrap;
    logic           sub_lit;
    logic [NC-1:0]  lit;

    rgbpwm_shift_chain #(.CHAIN_W(CHW)) u_chain (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .sclk_i  (sclk_i),
        .sdi_i   (sdi_i),
        .chain_o (chain),
        .sdo_o   (sdo_o)
    );

    rgbpwm_timebase #(.CODE_W(CW), .BRIGHT_W(BW)) u_time (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cnt_o  (cnt),
        .sub_o  (sub),
        .wrap_o (wrap)
    );

    rgbpwm_frame_latch #(.CHAIN_W(CHW), .BRIGHT_W(BW)) u_latch (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .strobe_i (strobe_i),
        .wrap_i   (wrap),
        .chain_i  (chain),
        .bright_i (bright_i),
        .active_o (active),
        .bright_o (bright_use)
    );

    assign sub_lit = (sub < bright_use);

    // Code j sits at the top end of the chain first: MSB of code 0 was sent first.
    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
            localparam int unsigned J = p * CHANNELS + c;
            logic [CW-1:0] code;
            assign code   = active[CHW-1-CW*J -: CW];
            assign lit[J] = (cnt < code);
        end
    end

    assign pwm_o = (gate_i && sub_lit) ? lit : '0;

    AST_RESET_DARK: assert property (@(posedge clk_i)
        rst_i |=> (pwm_o == '0 && sdo_o == 1'b0)); // R7
    AST_ZERO_BRIGHT_DARK: assert property (@(posedge clk_i) disable iff (rst_i)
        (bright_use == '0) |-> (pwm_o == '0)); // R4

endmodule

// File: tb/sim_rgbpwm_pixel_driver.sv
module sim_rgbpwm_pixel_driver;

    localparam int PERIOD = 255;
    localparam int FRAME  = 255 * 31;
    localparam int NBITS  = 384;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        strobe = 1'b0;
    logic        gate = 1'b1;
    logic [4:0]  bright = 5'd0;
    logic        sdo;
    logic [47:0] pwm;

    always #4 clk = ~clk;

    rgbpwm_pixel_driver u0 (
        .clk_i(clk), .rst_i(rst), .sclk_i(sclk), .sdi_i(sdi),
        .strobe_i(strobe), .gate_i(gate), .bright_i(bright),
        .sdo_o(sdo), .pwm_o(pwm)
    );

    // Cycles since reset release; the PWM phase is t mod 255.
    int t = 0;
    always @(posedge clk) t <= rst ? 0 : t + 1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int prev_seed = 101;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // seed 100: only code 0 at 255; seed 101: all zero
    function automatic int code_val(int seed, int j);
        if (seed == 101) return 0;
        if (seed == 100) return (j == 0) ? 255 : 0;
        if (j == 0) return 255;
        if (j == 47) return 0;
        return (j * 37 + seed * 53 + 11) & 255;
    endfunction

    function automatic bit stream_bit(int seed, int i);
        int v;
        v = code_val(seed, i / 8);
        return v[7 - (i % 8)];
    endfunction

    task automatic load(int seed);
        int mism;
        mism = 0;
        for (int i = 0; i < NBITS; i++) begin
            @(negedge clk);
            if (sdo !== stream_bit(prev_seed, i)) mism++;
            sdi = stream_bit(seed, i);
            @(negedge clk); sclk = 1'b1;
            @(negedge clk); sclk = 1'b0;
        end
        check(mism == 0, "R1", "sdo bits mismatching earlier stream", mism, 0);
        prev_seed = seed;
    endtask

    task automatic strobe_pulse();
        @(negedge clk); strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
    endtask

    task automatic wait_frame_start();
        @(negedge clk);
        while (t % FRAME != 0) @(negedge clk);
    endtask

    task automatic wait_phase(int ph);
        @(negedge clk);
        while (t % PERIOD != ph) @(negedge clk);
    endtask

    task automatic measure_frame(int seed, int br);
        int hi [48];
        for (int j = 0; j < 48; j++) hi[j] = 0;
        for (int k = 0; k < FRAME; k++) begin
            for (int j = 0; j < 48; j++) hi[j] += pwm[j];
            @(negedge clk);
        end
        for (int j = 0; j < 48; j++)
            check(hi[j] == code_val(seed, j) * br, "R4/R3/R8",
                  $sformatf("frame on-cycles ch%0d br%0d", j, br),
                  hi[j], code_val(seed, j) * br);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        check(pwm == '0, "R7", "pwm after reset", pwm, 0);
        check(sdo == 1'b0, "R7", "sdo after reset", sdo, 0);

        // R8: single lit channel maps to bit 0
        bright = 5'd31;
        load(100);
        strobe_pulse();
        wait_frame_start();
        wait_phase(10);
        check(pwm == 48'h1, "R8", "only red of pixel 0 lit", pwm, 1);

        // R6: gate blanks at once, resumes on release
        gate = 1'b0; #1;
        check(pwm == '0, "R6", "pwm same cycle gate low", pwm, 0);
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pwm != '0) cnt++;
        end
        check(cnt == 0, "R6", "cycles lit while gated", cnt, 0);
        gate = 1'b1; #1;
        check(pwm[0] == 1'b1, "R6", "pwm[0] after gate high", pwm[0], 1);

        // R2: shifting leaves display alone; strobe waits for period end
        load(101);
        @(negedge clk);
        check(pwm[0] == 1'b1, "R2", "pwm[0] after shifting new data", pwm[0], 1);
        wait_phase(50);
        strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
        cnt = 0;
        while (t % PERIOD != 0) begin
            if (!pwm[0]) cnt++;
            @(negedge clk);
        end
        check(cnt == 0, "R2", "dark cycles before boundary", cnt, 0);
        check(pwm[0] == 1'b0, "R2", "pwm[0] after boundary", pwm[0], 0);

        // R4 / R5: zero brightness is dark; a change waits for period end
        bright = 5'd0;
        load(100);
        strobe_pulse();
        wait_frame_start();
        wait_phase(5);
        check(pwm == '0, "R4", "pwm with brightness 0", pwm, 0);
        wait_phase(100);
        bright = 5'd31;
        cnt = 0;
        while (t % PERIOD != 0) begin
            if (pwm[0]) cnt++;
            @(negedge clk);
        end
        check(cnt == 0, "R5", "lit cycles before boundary", cnt, 0);
        check(pwm[0] == 1'b1, "R5", "pwm[0] after boundary", pwm[0], 1);

        // R3/R4/R8 sweeps over patterns and brightness values
        begin
            int seeds [4] = '{3, 7, 12, 20};
            int brs   [4] = '{31, 17, 1, 0};
            for (int s = 0; s < 4; s++) begin
                bright = brs[s][4:0];
                load(seeds[s]);
                strobe_pulse();
                wait_frame_start();
                measure_frame(seeds[s], brs[s]);
            end
        end

        // R7: reset mid-run clears everything, including the chain
        bright = 5'd31;
        load(3);
        strobe_pulse();
        wait_frame_start();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pwm == '0, "R7", "pwm after mid-run reset", pwm, 0);
        check(sdo == 1'b0, "R7", "sdo after mid-run reset", sdo, 0);
        prev_seed = 101;
        load(7);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule